// File: doc/BRIEF.md
# Audio Controller Interrupt Aggregator

This block collects every interrupt source of an audio host controller into one interrupt status word and drives a level-sensitive interrupt line. The sources are a two-bit response-ring status, one state-change bit per attached codec, and per-stream error and buffer-completion flags. Other blocks raise these flags with single-cycle set pulses. The aggregator holds them in write-1-to-clear registers until software clears them through a simple word-wide register port.

A controller summary bit reports ring activity and codec state changes. A codec state change counts only when the matching bit of a wake-enable mask, supplied as an input, is set. Each stream has its own summary bit, which follows only that stream's buffer-completion flag. A global summary bit is the OR of all the other summary bits. An interrupt control register holds a master enable and one enable for each summary source. The line is raised only when the master enable is set and some enabled summary bit is active.

Register map (byte addresses, 32-bit words, reads are combinational):
- 0x00 control: bit 31 master enable, bit 30 controller-source enable, bits 7:0 stream enables.
- 0x04 status word: read only. Bit 31 global summary, bit 30 controller summary, bits 7:0 stream summaries.
- 0x08 codec state change: bits 14:0.
- 0x0C ring status: bit 0 response flag, bit 1 overrun flag.
- 0x40 + 0x20*n stream n status: bit 0 buffer complete, bit 1 FIFO error, bit 2 descriptor error, bit 3 FIFO ready.

Streams 0 to 3 are the input streams. Streams 4 to 7 are the output streams.

Top module: `aud_irq_agg`

## Requirements
- R1: The controller summary bit (status word bit 30) is set when ring status bit 0 (response) or bit 1 (overrun) is set.
- R2: The controller summary bit is also set when any codec state-change bit is set together with the same bit of `wake_en`. A state change whose wake-enable bit is clear does not set it.
- R3: Stream summary bit n (status word bit n) is set only by stream n's buffer-complete bit. FIFO-error and descriptor-error bits do not affect it.
- R4: The global summary bit (status word bit 31) is set whenever any controller or stream summary bit is set.
- R5: `irq` is high only when control bit 31 is set and at least one of status bits 30 and 7:0 is set together with the same control bit. Otherwise `irq` is low.
- R6: Writing the codec register (0x08) clears each of bits 14:0 written as one. Bits written as zero are unchanged, and bits above 14 always read zero.
- R7: Writing a stream status register clears bits 0, 1 and 2 where ones are written. Bit 3 always reads the `strm_fifo_rdy` input and is unaffected by writes.
- R8: Stream n status sits at byte address 0x40 + 32*n. Inputs take n = 0..3 and outputs n = 4..7. Addresses in the stride that are not word 0 of a block read zero.
- R9: A set pulse is visible in its status register after the next clock edge. The status word and `irq` follow one clock edge later.
- R10: When a set pulse and a write-1-to-clear hit the same bit in the same cycle, the bit ends up set.
- R11: Reset clears all status registers, the control register and the status word, and drives `irq` low.
- R12: Writing the ring register (0x0C) clears each of its two bits written as one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 9 | Register byte address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| codec_set | input | 15 | Codec state-change set pulses |
| wake_en | input | 15 | Wake-enable mask for codec state changes |
| ring_resp_set | input | 1 | Ring response flag set pulse |
| ring_ovf_set | input | 1 | Ring overrun flag set pulse |
| strm_bc_set | input | 8 | Per-stream buffer-complete set pulses |
| strm_ferr_set | input | 8 | Per-stream FIFO-error set pulses |
| strm_derr_set | input | 8 | Per-stream descriptor-error set pulses |
| strm_fifo_rdy | input | 8 | Per-stream FIFO-ready levels |
| int_status | output | 32 | Registered interrupt status word |
| irq | output | 1 | Level interrupt line |

## Verification
The assertions assume that `wake_en` and the set pulses are clean 0/1 values sampled at the clock edge. They also assume that `rst` is held for at least one edge before the first checked cycle, since the past-value checks compare against the values the registers held during reset. The bench changes every input only at the falling clock edge. It keeps set pulses one cycle wide and holds reset for several cycles at start-up and in the mid-run reset test.

// File: rtl/aud_irq_pkg.sv
package aud_irq_pkg;

    localparam int AIQ_DW         = 32;
    localparam int AIQ_AW         = 9;
    localparam int AIQ_CODECS     = 15;
    localparam int AIQ_IN_STRM    = 4;
    localparam int AIQ_OUT_STRM   = 4;
    localparam int AIQ_STRIDE     = 32;
    localparam int AIQ_CTL_ADDR   = 'h00;
    localparam int AIQ_STS_ADDR   = 'h04;
    localparam int AIQ_CODEC_ADDR = 'h08;
    localparam int AIQ_RING_ADDR  = 'h0C;
    localparam int AIQ_STRM_BASE  = 'h40;
    localparam int AIQ_GLB_BIT    = 31;
    localparam int AIQ_CTRL_BIT   = 30;

    // bit 0 buffer complete, bit 1 FIFO error, bit 2 descriptor error
    typedef struct packed {
        logic derr;
        logic ferr;
        logic bc;
    } strm_flags_t;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_CTL,
        SEL_STS,
        SEL_CODEC,
        SEL_RING,
        SEL_STRM
    } reg_sel_t;

    // Writable bits of the control register for a given stream count
    function automatic logic [AIQ_DW-1:0] ctl_mask(input int ns);
        logic [AIQ_DW-1:0] m;
        m = '0;
        m[AIQ_GLB_BIT]  = 1'b1;
        m[AIQ_CTRL_BIT] = 1'b1;
        for (int i = 0; i < ns; i++) m[i] = 1'b1;
        return m;
    endfunction

endpackage

// File: rtl/aud_irq_w1c.sv
module aud_irq_w1c #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] set,
    input  logic         clr_en,
    input  logic [W-1:0] clr_mask,
    output logic [W-1:0] q
);

    logic [W-1:0] clr_eff;

    assign clr_eff = clr_en ? clr_mask : '0;

    // hardware set has priority over a software clear in the same cycle
    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= set | (q & ~clr_eff);
    end

    AST_SET_WINS: assert property (@(posedge clk) disable iff (rst) (|set) |=> ((q & $past(set)) == $past(set))); // R10
    AST_ZERO_KEEPS: assert property (@(posedge clk) disable iff (rst) clr_en |=> ((q & ~$past(clr_mask)) == (($past(q) | $past(set)) & ~$past(clr_mask)))); // R6

endmodule

// File: rtl/aud_irq_summary.sv
module aud_irq_summary #(
    parameter int NC = 15,
    parameter int NS = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [1:0]    ring,
    input  logic [NC-1:0] codec,
    input  logic [NC-1:0] wake,
    input  logic [NS-1:0] bc,
    input  logic          gie,
    input  logic          ctrl_en,
    input  logic [NS-1:0] strm_en,
    output logic          glb_q,
    output logic          ctrl_q,
    output logic [NS-1:0] strm_q,
    output logic          irq_q
);

    typedef struct packed {
        logic          glb;
        logic          ctrl;
        logic [NS-1:0] strm;
    } sum_t;

    sum_t sum_n, sum_r;
    logic irq_n;

    always_comb begin
        sum_n.ctrl = (|ring) | (|(codec & wake));
        sum_n.strm = bc;
        sum_n.glb  = sum_n.ctrl | (|sum_n.strm);
        irq_n      = gie & ((sum_n.ctrl & ctrl_en) | (|(sum_n.strm & strm_en)));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sum_r <= '0;
            irq_q <= 1'b0;
        end else begin
            sum_r <= sum_n;
            irq_q <= irq_n;
        end
    end

    assign glb_q  = sum_r.glb;
    assign ctrl_q = sum_r.ctrl;
    assign strm_q = sum_r.strm;

    AST_RING_SOURCE: assert property (@(posedge clk) disable iff (rst) $past(|ring) |-> ctrl_q); // R1
    AST_WAKE_SOURCE: assert property (@(posedge clk) disable iff (rst) $past(|(codec & wake)) |-> ctrl_q); // R2
    AST_STRM_ONLY_BC: assert property (@(posedge clk) disable iff (rst) (strm_q & ~$past(bc)) == '0); // R3
    AST_GLB_FROM_ANY: assert property (@(posedge clk) disable iff (rst) glb_q |-> $past((|ring) | (|(codec & wake)) | (|bc))); // R4
    AST_LINE_NEEDS_GLB: assert property (@(posedge clk) disable iff (rst) irq_q |-> glb_q); // R5
    AST_LINE_NEEDS_GIE: assert property (@(posedge clk) disable iff (rst) irq_q |-> $past(gie)); // R5
    AST_RESET_QUIET: assert property (@(posedge clk) rst |=> !irq_q); // R11

endmodule

// File: rtl/aud_irq_agg.sv
module aud_irq_agg
    import aud_irq_pkg::*;
#(
    parameter int DW   = AIQ_DW,
    parameter int AW   = AIQ_AW,
    parameter int NC   = AIQ_CODECS,
    parameter int NIN  = AIQ_IN_STRM,
    parameter int NOUT = AIQ_OUT_STRM
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  reg_wr,
    input  logic [AW-1:0]         reg_addr,
    input  logic [DW-1:0]         reg_wdata,
    output logic [DW-1:0]         reg_rdata,
    input  logic [NC-1:0]         codec_set,
    input  logic [NC-1:0]         wake_en,
    input  logic                  ring_resp_set,
    input  logic                  ring_ovf_set,
    input  logic [NIN+NOUT-1:0]   strm_bc_set,
    input  logic [NIN+NOUT-1:0]   strm_ferr_set,
    input  logic [NIN+NOUT-1:0]   strm_derr_set,
    input  logic [NIN+NOUT-1:0]   strm_fifo_rdy,
    output logic [DW-1:0]         int_status,
    output logic                  irq
);

    localparam int NS    = NIN + NOUT;
    localparam int SHIFT = $clog2(AIQ_STRIDE);
    localparam int IDX_W = (NS > 1) ? $clog2(NS) : 1;
    localparam logic [DW-1:0] CTL_WMASK = ctl_mask(NS);

    reg_sel_t            sel;
    logic [IDX_W-1:0]    sidx;
    logic [AW-1:0]       soff;
    logic [AW-SHIFT-1:0] sblk;
    logic [DW-1:0]       ctl_q;
    logic [NC-1:0]       codec_q;
    logic [1:0]          ring_q;
    strm_flags_t [NS-1:0] strm_q;
    logic [NS-1:0]       bc_vec;
    logic                glb_s, ctrl_s;
    logic [NS-1:0]       strm_s;

    // address decode: fixed words, then the strided stream blocks
    assign soff = reg_addr - AW'(AIQ_STRM_BASE);
    assign sblk = soff[AW-1:SHIFT];

    always_comb begin
        sel  = SEL_NONE;
        sidx = '0;
        if (reg_addr == AW'(AIQ_CTL_ADDR))        sel = SEL_CTL;
        else if (reg_addr == AW'(AIQ_STS_ADDR))   sel = SEL_STS;
        else if (reg_addr == AW'(AIQ_CODEC_ADDR)) sel = SEL_CODEC;
        else if (reg_addr == AW'(AIQ_RING_ADDR))  sel = SEL_RING;
        else if (reg_addr >= AW'(AIQ_STRM_BASE) && soff[SHIFT-1:0] == '0
                 && int'(sblk) < NS) begin
            sel  = SEL_STRM;
            sidx = IDX_W'(sblk);
        end
    end

    always_ff @(posedge clk) begin
        if (rst)                         ctl_q <= '0;
        else if (reg_wr && sel == SEL_CTL) ctl_q <= reg_wdata & CTL_WMASK;
    end

    aud_irq_w1c #(.W(NC)) u_codec (
        .clk(clk), .rst(rst), .set(codec_set),
        .clr_en(reg_wr && sel == SEL_CODEC), .clr_mask(reg_wdata[NC-1:0]),
        .q(codec_q)
    );

    aud_irq_w1c #(.W(2)) u_ring (
        .clk(clk), .rst(rst), .set({ring_ovf_set, ring_resp_set}),
        .clr_en(reg_wr && sel == SEL_RING), .clr_mask(reg_wdata[1:0]),
        .q(ring_q)
    );

    for (genvar i = 0; i < NS; i++) begin : g_strm
        logic [2:0] q3;
        aud_irq_w1c #(.W(3)) u_sts (
            .clk(clk), .rst(rst),
            .set({strm_derr_set[i], strm_ferr_set[i], strm_bc_set[i]}),
            .clr_en(reg_wr && sel == SEL_STRM && sidx == IDX_W'(i)),
            .clr_mask(reg_wdata[2:0]),
            .q(q3)
        );
        assign strm_q[i] = q3;
        assign bc_vec[i] = strm_q[i].bc;
    end

    aud_irq_summary #(.NC(NC), .NS(NS)) u_sum (
        .clk(clk), .rst(rst),
        .ring(ring_q), .codec(codec_q), .wake(wake_en), .bc(bc_vec),
        .gie(ctl_q[AIQ_GLB_BIT]), .ctrl_en(ctl_q[AIQ_CTRL_BIT]),
        .strm_en(ctl_q[NS-1:0]),
        .glb_q(glb_s), .ctrl_q(ctrl_s), .strm_q(strm_s), .irq_q(irq)
    );

    always_comb begin
        int_status               = '0;
        int_status[AIQ_GLB_BIT]  = glb_s;
        int_status[AIQ_CTRL_BIT] = ctrl_s;
        int_status[NS-1:0]       = strm_s;
    end

    always_comb begin
        unique case (sel)
            SEL_CTL:   reg_rdata = ctl_q;
            SEL_STS:   reg_rdata = int_status;
            SEL_CODEC: reg_rdata = DW'(codec_q);
            SEL_RING:  reg_rdata = DW'(ring_q);
            SEL_STRM:  reg_rdata = DW'({strm_fifo_rdy[sidx], strm_q[sidx]});
            default:   reg_rdata = '0;
        endcase
    end

    AST_FIFO_RDY_PASS: assert property (@(posedge clk) disable iff (rst) (sel == SEL_STRM) |-> (reg_rdata[3] == strm_fifo_rdy[sidx])); // R7
    AST_CTL_RESET: assert property (@(posedge clk) rst |=> (ctl_q == '0 && int_status == '0)); // R11

endmodule

// File: tb/sim_aud_irq_agg.sv
module sim_aud_irq_agg;

    localparam int CLK_PERIOD = 10;
    localparam logic [8:0] A_CTL = 9'h000, A_STS = 9'h004, A_CODEC = 9'h008,
                           A_RING = 9'h00C, A_SBASE = 9'h040;

    typedef struct packed {
        logic [14:0] cset;
        logic [14:0] wake;
        logic [1:0]  ring;   // {ovf, resp}
        logic [7:0]  bc;
        logic [7:0]  fe;
        logic [31:0] ctl;
        logic [31:0] exp_sts;
        logic        exp_irq;
    } vec_t;

    localparam int NV = 7;
    localparam vec_t VECS [NV] = '{
        '{15'h0000, 15'h0000, 2'b01, 8'h00, 8'h00, 32'hC000_0000, 32'hC000_0000, 1'b1},
        '{15'h0000, 15'h0000, 2'b10, 8'h00, 8'h00, 32'h8000_0000, 32'hC000_0000, 1'b0},
        '{15'h0004, 15'h0004, 2'b00, 8'h00, 8'h00, 32'h4000_0000, 32'hC000_0000, 1'b0},
        '{15'h0004, 15'h0003, 2'b00, 8'h00, 8'h00, 32'hC000_0000, 32'h0000_0000, 1'b0},
        '{15'h0000, 15'h0000, 2'b00, 8'h20, 8'h01, 32'h8000_0020, 32'h8000_0020, 1'b1},
        '{15'h0000, 15'h0000, 2'b00, 8'h01, 8'h02, 32'h8000_00FE, 32'h8000_0001, 1'b0},
        '{15'h4000, 15'h4000, 2'b00, 8'h80, 8'h00, 32'h8000_0080, 32'hC000_0080, 1'b1}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [8:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [14:0] codec_set = '0, wake_en = '0;
    logic        ring_resp_set = 1'b0, ring_ovf_set = 1'b0;
    logic [7:0]  strm_bc_set = '0, strm_ferr_set = '0, strm_derr_set = '0, strm_fifo_rdy = '0;
    logic [31:0] int_status;
    logic        irq;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    aud_irq_agg u0 (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .codec_set(codec_set), .wake_en(wake_en),
        .ring_resp_set(ring_resp_set), .ring_ovf_set(ring_ovf_set),
        .strm_bc_set(strm_bc_set), .strm_ferr_set(strm_ferr_set),
        .strm_derr_set(strm_derr_set), .strm_fifo_rdy(strm_fifo_rdy),
        .int_status(int_status), .irq(irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [8:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [8:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic pulse(input logic [14:0] cs, input logic [1:0] rg,
                         input logic [7:0] bc, input logic [7:0] fe, input logic [7:0] de);
        @(negedge clk);
        codec_set = cs; {ring_ovf_set, ring_resp_set} = rg;
        strm_bc_set = bc; strm_ferr_set = fe; strm_derr_set = de;
        @(negedge clk);
        codec_set = '0; {ring_ovf_set, ring_resp_set} = 2'b00;
        strm_bc_set = '0; strm_ferr_set = '0; strm_derr_set = '0;
    endtask

    task automatic clear_all();
        wr(A_CODEC, 32'hFFFF_FFFF);
        wr(A_RING, 32'h3);
        for (int s = 0; s < 8; s++) wr(A_SBASE + 9'(s * 32), 32'h7);
    endtask

    task automatic report();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            report();
        end
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R11: reset state
        check("R11 irq after reset", 32'(irq), 32'h0);
        check("R11 status after reset", int_status, 32'h0);
        rd(A_CTL, d);   check("R11 control after reset", d, 32'h0);
        rd(A_CODEC, d); check("R11 codec after reset", d, 32'h0);

        // Table walk: R1 R2 R3 R4 R5
        for (int v = 0; v < NV; v++) begin
            clear_all();
            wake_en = VECS[v].wake;
            wr(A_CTL, VECS[v].ctl);
            pulse(VECS[v].cset, VECS[v].ring, VECS[v].bc, VECS[v].fe, 8'h00);
            repeat (2) @(negedge clk);
            check($sformatf("R1 R2 R3 R4 vector %0d status", v), int_status, VECS[v].exp_sts);
            check($sformatf("R5 vector %0d irq", v), 32'(irq), 32'(VECS[v].exp_irq));
        end

        // R9: latency of status register, then summary and line
        clear_all();
        wake_en = '0;
        wr(A_CTL, 32'h8000_0004);
        repeat (2) @(negedge clk);
        @(negedge clk);
        strm_bc_set = 8'h04; reg_addr = A_SBASE + 9'd64;
        @(negedge clk);
        strm_bc_set = 8'h00;
        #1;
        check("R9 stream status one edge after set", reg_rdata, 32'h1);
        check("R9 status word not yet updated", int_status, 32'h0);
        check("R9 irq not yet raised", 32'(irq), 32'h0);
        @(negedge clk);
        check("R9 status word second edge", int_status, 32'h8000_0004);
        check("R9 irq second edge", 32'(irq), 32'h1);

        // R10: set and clear collide
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = A_SBASE + 9'd64; reg_wdata = 32'h1; strm_bc_set = 8'h04;
        @(negedge clk);
        reg_wr = 1'b0; strm_bc_set = 8'h00;
        rd(A_SBASE + 9'd64, d); check("R10 set wins over clear", d, 32'h1);
        wr(A_SBASE + 9'd64, 32'h1);
        rd(A_SBASE + 9'd64, d); check("R7 buffer-complete cleared", d, 32'h0);
        repeat (2) @(negedge clk);
        check("R5 irq drops after clear", 32'(irq), 32'h0);

        // R6: codec register write-1-to-clear
        pulse(15'h0005, 2'b00, 8'h00, 8'h00, 8'h00);
        wr(A_CODEC, 32'h0);
        rd(A_CODEC, d); check("R6 zeros keep codec bits", d, 32'h5);
        wr(A_CODEC, 32'h1);
        rd(A_CODEC, d); check("R6 one clears single bit", d, 32'h4);
        pulse(15'h7FFF, 2'b00, 8'h00, 8'h00, 8'h00);
        rd(A_CODEC, d); check("R6 fifteen codec bits", d, 32'h7FFF);
        wr(A_CODEC, 32'hFFFF_FFFF);
        rd(A_CODEC, d); check("R6 all cleared", d, 32'h0);

        // R7: stream status bits and read-only FIFO ready
        strm_fifo_rdy = 8'h08;
        pulse(15'h0, 2'b00, 8'h08, 8'h08, 8'h08);
        rd(A_SBASE + 9'h060, d); check("R7 stream 3 all flags", d, 32'hF);
        wr(A_SBASE + 9'h060, 32'hF);
        rd(A_SBASE + 9'h060, d); check("R7 fifo ready survives write", d, 32'h8);
        strm_fifo_rdy = 8'h00;
        rd(A_SBASE + 9'h060, d); check("R7 fifo ready follows input", d, 32'h0);

        // R8: strided addressing, output stream 1 is stream 5
        pulse(15'h0, 2'b00, 8'h00, 8'h00, 8'h20);
        rd(9'h0E0, d); check("R8 stream 5 at 0xE0", d, 32'h4);
        rd(9'h060, d); check("R8 stream 1 unaffected", d, 32'h0);
        rd(9'h0E4, d); check("R8 non-zero word in block", d, 32'h0);
        repeat (2) @(negedge clk);
        check("R3 descriptor error no summary", int_status & 32'hFF, 32'h0);
        wr(9'h0E0, 32'h4);

        // R12: ring status clear
        pulse(15'h0, 2'b11, 8'h00, 8'h00, 8'h00);
        rd(A_RING, d); check("R12 both ring flags", d, 32'h3);
        wr(A_RING, 32'h1);
        rd(A_RING, d); check("R12 clear response only", d, 32'h2);
        wr(A_RING, 32'h2);
        rd(A_RING, d); check("R12 clear overrun", d, 32'h0);

        // R11: reset in the middle of activity
        wr(A_CTL, 32'hC000_0000);
        pulse(15'h0, 2'b01, 8'h00, 8'h00, 8'h00);
        repeat (2) @(negedge clk);
        check("R5 irq before mid reset", 32'(irq), 32'h1);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        check("R11 irq after mid reset", 32'(irq), 32'h0);
        check("R11 status after mid reset", int_status, 32'h0);
        rd(A_RING, d); check("R11 ring after mid reset", d, 32'h0);
        rd(A_CTL, d);  check("R11 control after mid reset", d, 32'h0);

        done = 1'b1;
        report();
    end

endmodule